// File: doc/BRIEF.md
# PWM Generator Fault Combiner

This block decides when one PWM generator must stop driving its load. It watches four external fault pins and eight digital-comparator trigger lines. Each pin has its own polarity setting, and the pins pass through a two-flop synchronizer. Two enable masks pick the contributing sources: one mask for the pins and one for the triggers. Every enabled source is ORed into a single raw fault, and both groups can take part at the same time. A compatibility mode ignores both masks and watches pin 0 alone.

The raw fault sets a registered fault-active flag. The flag either tracks the raw condition or latches until software clears it. An optional counter holds each fault for a programmed minimum number of clock cycles. While the flag is high, both PWM outputs take programmed safe levels in the same cycle, with no software involved. After the fault goes away, the outputs stay forced until the next period-start pulse from the counter logic, which gives cycle-by-cycle current limiting. An interrupt status bit records each new fault.

Configuration uses a small write-only register port. A write is captured on the rising clock edge while `cfg_we` is high.

Top module: `pwm_fault_combiner`

## Requirements
- R1: After reset, `fault_active` and `fault_irq` are 0, and `pwm_a_out`/`pwm_b_out` follow `pwm_a_in`/`pwm_b_in`. All registers reset to 0. That means compatibility mode, transient behaviour, no stretch, active-high pins and safe levels of 0.
- R2: External pin n counts as active when `fault_pin[n]` XOR the polarity bit is 1. The polarity bits are at address 1, bits [7:4], where 1 means active-low. Pin n is enabled by address 1, bit n. A pin change sampled at clock edge k shows on `fault_active` after edge k+2, not earlier.
- R3: With extended mode on (address 0, bit 0), trigger line m contributes when address 2, bit m is 1. A trigger sampled at edge k shows on `fault_active` after edge k.
- R4: The fault is the OR of every enabled pin and every enabled trigger, and both groups contribute together. A source whose enable bit is 0 has no effect.
- R5: With extended mode off, only pin 0 (after its polarity) causes a fault, and both enable masks are ignored.
- R6: In transient mode (address 0, bit 1 = 0) with no stretch, `fault_active` falls after the first edge at which the raw fault is absent.
- R7: In latched mode (address 0, bit 1 = 1), `fault_active` stays high after the sources go away. Writing 1 to address 4, bit 0 clears it at that write's edge. The same write has no effect while a source is still active.
- R8: With the stretch enabled (address 0, bit 2) and a count M ≥ 1 at address 3, a fault onset keeps `fault_active` high for at least M cycles. A raw fault longer than M ends one cycle after the source goes away.
- R9: In every cycle in which `fault_active` is high, `pwm_a_out` equals address 0, bit 4, and `pwm_b_out` equals address 0, bit 5.
- R10: Once `fault_active` has fallen, the outputs stay at the safe levels. They return to the inputs after the first edge at which `period_start` is sampled high while no fault is active.
- R11: `fault_irq` goes high in the same cycle as a rising `fault_active`. Writing 1 to address 4, bit 1 clears it, and a new rising fault in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (0 control, 1 pins, 2 triggers, 3 stretch count, 4 command) |
| cfg_wdata | input | 16 | Register write data |
| fault_pin | input | 4 | Asynchronous external fault pins |
| dcmp_trig | input | 8 | Synchronous digital-comparator trigger lines |
| period_start | input | 1 | One-cycle pulse at each PWM period start |
| pwm_a_in | input | 1 | PWM signal A from the counter logic |
| pwm_b_in | input | 1 | PWM signal B from the counter logic |
| pwm_a_out | output | 1 | Gated PWM signal A |
| pwm_b_out | output | 1 | Gated PWM signal B |
| fault_active | output | 1 | Generator fault flag |
| fault_irq | output | 1 | Fault interrupt status |

## Verification
Each result has its own delay. A trigger reaches `fault_active` one edge after it is sampled. A pin takes three edges, because of the two synchronizer stages plus the state flop. The gated outputs and `fault_irq` change in the same cycle as the flag, and a command write takes effect at the edge that captures it. The bench drives all inputs on the falling edge and samples on the falling edge that follows the edge where a result is due. For pin faults it also samples one edge early and expects no fault yet. The stretch check counts the high cycles of `fault_active` one falling edge at a time and compares the count with the programmed minimum.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    localparam int PFC_NPIN   = 4;
    localparam int PFC_NTRIG  = 8;
    localparam int PFC_DW     = 16;
    localparam int PFC_AW     = 3;
    localparam int PFC_CNT_W  = 16;
    localparam int PFC_POL_LO = 4;

    typedef enum logic [PFC_AW-1:0] {
        ADR_CTRL   = 3'd0,
        ADR_PINS   = 3'd1,
        ADR_TRIG   = 3'd2,
        ADR_MINPER = 3'd3,
        ADR_CMD    = 3'd4
    } pfc_addr_e;

    typedef struct packed {
        logic                 ext_en;
        logic                 latch_en;
        logic                 stretch_en;
        logic                 safe_a;
        logic                 safe_b;
        logic [PFC_NPIN-1:0]  pin_mask;
        logic [PFC_NPIN-1:0]  pin_pol;
        logic [PFC_NTRIG-1:0] trig_mask;
        logic [PFC_CNT_W-1:0] minper;
    } pfc_cfg_t;

    function automatic logic [PFC_NPIN-1:0] pfc_pin_level(
        input logic [PFC_NPIN-1:0] synced,
        input logic [PFC_NPIN-1:0] pol
    );
        return synced ^ pol;
    endfunction

    function automatic logic [PFC_CNT_W-1:0] pfc_stretch_load(
        input logic [PFC_CNT_W-1:0] minper
    );
        return (minper == '0) ? '0 : minper - 1'b1;
    endfunction

endpackage

// File: rtl/pfc_regs.sv
module pfc_regs
    import pfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [PFC_AW-1:0] addr,
    input  logic [PFC_DW-1:0] wdata,
    output pfc_cfg_t          cfg,
    output logic              clr_fault,
    output logic              clr_irq
);
    localparam int CMD_FAULT_BIT = 0;
    localparam int CMD_IRQ_BIT   = 1;

    pfc_addr_e adr;
    assign adr = pfc_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            case (adr)
                ADR_CTRL: begin
                    cfg.ext_en     <= wdata[0];
                    cfg.latch_en   <= wdata[1];
                    cfg.stretch_en <= wdata[2];
                    cfg.safe_a     <= wdata[4];
                    cfg.safe_b     <= wdata[5];
                end
                ADR_PINS: begin
                    cfg.pin_mask <= wdata[PFC_NPIN-1:0];
                    cfg.pin_pol  <= wdata[PFC_POL_LO +: PFC_NPIN];
                end
                ADR_TRIG:   cfg.trig_mask <= wdata[PFC_NTRIG-1:0];
                ADR_MINPER: cfg.minper    <= wdata[PFC_CNT_W-1:0];
                default: ;
            endcase
        end
    end

    assign clr_fault = we && (adr == ADR_CMD) && wdata[CMD_FAULT_BIT];
    assign clr_irq   = we && (adr == ADR_CMD) && wdata[CMD_IRQ_BIT];

endmodule

// File: rtl/pfc_sync.sv
module pfc_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/pfc_combine.sv
module pfc_combine
    import pfc_pkg::*;
(
    input  logic [PFC_NPIN-1:0]  pin_sync,
    input  logic [PFC_NTRIG-1:0] trig,
    input  pfc_cfg_t             cfg,
    output logic [PFC_NPIN-1:0]  pin_level,
    output logic                 raw_fault
);
    logic [PFC_NPIN-1:0]  pin_en;
    logic [PFC_NTRIG-1:0] trig_en;

    always_comb begin
        pin_level = pfc_pin_level(pin_sync, cfg.pin_pol);
        if (cfg.ext_en) begin
            pin_en  = cfg.pin_mask;
            trig_en = cfg.trig_mask;
        end else begin
            pin_en  = PFC_NPIN'(1);
            trig_en = '0;
        end
        raw_fault = (|(pin_level & pin_en)) | (|(trig & trig_en));
    end

endmodule

// File: rtl/pfc_fault_state.sv
module pfc_fault_state
    import pfc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 raw,
    input  logic                 latch_en,
    input  logic                 stretch_en,
    input  logic [PFC_CNT_W-1:0] minper,
    input  logic                 clr_fault,
    input  logic                 clr_irq,
    input  logic                 period_start,
    output logic                 fault_q,
    output logic                 irq_q,
    output logic                 force_safe
);
    logic                 latch_q, latch_n;
    logic [PFC_CNT_W-1:0] cnt_q;
    logic                 stretch, onset, fault_n, block_q;

    always_comb begin
        latch_n = latch_en & (raw | (latch_q & ~(clr_fault & ~raw)));
        stretch = stretch_en & (cnt_q != '0);
        fault_n = raw | stretch | latch_n;
        onset   = fault_n & ~fault_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= 1'b0;
            fault_q <= 1'b0;
            cnt_q   <= '0;
            irq_q   <= 1'b0;
            block_q <= 1'b0;
        end else begin
            latch_q <= latch_n;
            fault_q <= fault_n;
            if (raw && !fault_q)  cnt_q <= pfc_stretch_load(minper);
            else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            irq_q   <= onset | (irq_q & ~clr_irq);
            if (fault_q)           block_q <= 1'b1;
            else if (period_start) block_q <= 1'b0;
        end
    end

    assign force_safe = fault_q | block_q;

    p_latch_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (latch_en && latch_q && raw) |=> fault_q);

    p_follow_live_r6: assert property (@(posedge clk) disable iff (rst)
        (!latch_en && !stretch_en && !raw) |=> !fault_q);

    p_min_stretch_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(fault_q) && stretch_en && minper >= 2) |=> fault_q);

    p_irq_on_rise_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_q) |-> irq_q);

    p_resume_gate_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_q) |-> force_safe);

endmodule

// File: rtl/pwm_fault_combiner.sv
module pwm_fault_combiner
    import pfc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [PFC_AW-1:0]    cfg_addr,
    input  logic [PFC_DW-1:0]    cfg_wdata,
    input  logic [PFC_NPIN-1:0]  fault_pin,
    input  logic [PFC_NTRIG-1:0] dcmp_trig,
    input  logic                 period_start,
    input  logic                 pwm_a_in,
    input  logic                 pwm_b_in,
    output logic                 pwm_a_out,
    output logic                 pwm_b_out,
    output logic                 fault_active,
    output logic                 fault_irq
);
    pfc_cfg_t            cfg;
    logic                clr_fault, clr_irq;
    logic [PFC_NPIN-1:0] pin_sync, pin_level;
    logic                raw_fault, force_safe;

    pfc_regs u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .cfg(cfg), .clr_fault(clr_fault), .clr_irq(clr_irq)
    );

    pfc_sync #(.W(PFC_NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(fault_pin), .q(pin_sync)
    );

    pfc_combine u_comb (
        .pin_sync(pin_sync), .trig(dcmp_trig), .cfg(cfg),
        .pin_level(pin_level), .raw_fault(raw_fault)
    );

    pfc_fault_state u_state (
        .clk(clk), .rst(rst), .raw(raw_fault),
        .latch_en(cfg.latch_en), .stretch_en(cfg.stretch_en), .minper(cfg.minper),
        .clr_fault(clr_fault), .clr_irq(clr_irq), .period_start(period_start),
        .fault_q(fault_active), .irq_q(fault_irq), .force_safe(force_safe)
    );

    assign pwm_a_out = force_safe ? cfg.safe_a : pwm_a_in;
    assign pwm_b_out = force_safe ? cfg.safe_b : pwm_b_in;

    p_safe_out_r9: assert property (@(posedge clk) disable iff (rst)
        fault_active |-> (pwm_a_out == cfg.safe_a && pwm_b_out == cfg.safe_b));

    p_legacy_pin0_r5: assert property (@(posedge clk) disable iff (rst)
        (!cfg.ext_en && !pin_level[0]) |-> !raw_fault);

    p_trig_path_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg.ext_en && |(dcmp_trig & cfg.trig_mask)) |=> fault_active);

endmodule

// File: tb/pwm_fault_combiner_tb.sv
`timescale 1ns/1ps
module pwm_fault_combiner_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [3:0]  fault_pin = '0;
    logic [7:0]  dcmp_trig = '0;
    logic        period_start = 1'b0;
    logic        pwm_a_in = 1'b1;
    logic        pwm_b_in = 1'b0;
    logic        pwm_a_out, pwm_b_out, fault_active, fault_irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pwm_fault_combiner u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .fault_pin(fault_pin), .dcmp_trig(dcmp_trig),
        .period_start(period_start), .pwm_a_in(pwm_a_in), .pwm_b_in(pwm_b_in),
        .pwm_a_out(pwm_a_out), .pwm_b_out(pwm_b_out),
        .fault_active(fault_active), .fault_irq(fault_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic resume_outputs();
        period_start = 1'b1;
        @(negedge clk);
        period_start = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 fault_active", fault_active, 0);
        chk("R1 fault_irq", fault_irq, 0);
        chk("R1 pass-through", {pwm_a_out, pwm_b_out}, 2'b10);
    endtask

    task automatic t_legacy();
        wr(3'd2, 16'h00ff);
        wr(3'd1, 16'h0000);
        dcmp_trig = 8'hff; fault_pin = 4'b1110;
        step(4);
        chk("R5 masks ignored, pins1-3/triggers", fault_active, 0);
        dcmp_trig = 8'h00;
        fault_pin = 4'b0001;
        step(2);
        chk("R2 no fault before sync delay", fault_active, 0);
        step(1);
        chk("R5 pin0 fault", fault_active, 1);
        chk("R9 safe levels", {pwm_a_out, pwm_b_out}, 2'b00);
        chk("R11 irq set", fault_irq, 1);
        fault_pin = 4'b0000;
        step(3);
        chk("R6 transient release", fault_active, 0);
        chk("R10 still forced", {pwm_a_out, pwm_b_out}, 2'b00);
        step(2);
        chk("R10 forced without period start", pwm_a_out, 0);
        resume_outputs();
        chk("R10 resumed", {pwm_a_out, pwm_b_out}, 2'b10);
        wr(3'd4, 16'h0002);
        chk("R11 irq cleared", fault_irq, 0);
    endtask

    task automatic t_polarity();
        fault_pin = 4'b0100;
        wr(3'd0, 16'h0031);
        wr(3'd1, 16'h0044);
        step(4);
        chk("R2 active-low idle high", fault_active, 0);
        fault_pin = 4'b0000;
        step(2);
        chk("R2 pin2 latency", fault_active, 0);
        step(1);
        chk("R2 pin2 active low fault", fault_active, 1);
        chk("R9 programmed safe levels", {pwm_a_out, pwm_b_out}, 2'b11);
        fault_pin = 4'b0100;
        step(3);
        chk("R6 pin2 released", fault_active, 0);
        resume_outputs();
        fault_pin = 4'b0110;
        step(4);
        chk("R4 unmasked pin1 ignored", fault_active, 0);
        fault_pin = 4'b0100;
    endtask

    task automatic t_trigger();
        wr(3'd2, 16'h0020);
        dcmp_trig = 8'h10;
        step(2);
        chk("R4 unmasked trigger ignored", fault_active, 0);
        dcmp_trig = 8'h20;
        step(1);
        chk("R3 trigger fault next edge", fault_active, 1);
        fault_pin = 4'b0000;
        step(3);
        dcmp_trig = 8'h00;
        step(2);
        chk("R4 pin keeps fault after trigger drops", fault_active, 1);
        fault_pin = 4'b0100;
        step(3);
        chk("R4 both released", fault_active, 0);
        resume_outputs();
        wr(3'd4, 16'h0002);
    endtask

    task automatic t_latched();
        wr(3'd0, 16'h0003);
        dcmp_trig = 8'h20;
        step(1);
        dcmp_trig = 8'h00;
        step(5);
        chk("R7 latched holds", fault_active, 1);
        dcmp_trig = 8'h20;
        wr(3'd4, 16'h0001);
        step(1);
        chk("R7 clear ignored while source active", fault_active, 1);
        dcmp_trig = 8'h00;
        step(3);
        chk("R7 still latched", fault_active, 1);
        wr(3'd4, 16'h0001);
        chk("R7 cleared by write", fault_active, 0);
        resume_outputs();
        wr(3'd4, 16'h0002);
    endtask

    task automatic t_stretch();
        int hi;
        wr(3'd3, 16'd6);
        wr(3'd0, 16'h0005);
        dcmp_trig = 8'h20;
        @(negedge clk);
        dcmp_trig = 8'h00;
        hi = (fault_active === 1'b1) ? 1 : 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (fault_active === 1'b1) hi++;
        end
        chk("R8 short pulse stretched to 6", hi, 6);
        dcmp_trig = 8'h20;
        hi = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (fault_active === 1'b1) hi++;
        end
        dcmp_trig = 8'h00;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (fault_active === 1'b1) hi++;
        end
        chk("R8 long pulse not extended", hi, 10);
        resume_outputs();
    endtask

    task automatic t_irq_priority();
        wr(3'd0, 16'h0001);
        wr(3'd4, 16'h0002);
        chk("R11 clear before", fault_irq, 0);
        dcmp_trig = 8'h20;
        wr(3'd4, 16'h0002);
        chk("R11 set wins over clear", fault_irq, 1);
        dcmp_trig = 8'h00;
        step(2);
        wr(3'd4, 16'h0001);
        chk("R11 clear-fault write leaves irq", fault_irq, 1);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_legacy();
        t_polarity();
        t_trigger();
        t_latched();
        t_stretch();
        t_irq_priority();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

endmodule